// File: doc/BRIEF.md
# Receive FIFO Watermark Controller

This block follows how full the 2048-byte receive FIFO of an Ethernet receive path is. It does not store the data. It counts bytes as the MAC receiver writes them and as the DMA engine reads them. From that count it derives a bus-priority request for the DMA engine, with three levels. When the FIFO becomes critically full, it also asks the MAC transmit side to send a PAUSE frame, so that the bytes already received can be drained before more arrive.

There are two watermarks. At 1024 bytes the priority is raised above normal. At 1536 bytes it is forced to the highest level, and a one-cycle PAUSE request is issued. Each level is released only after the count has dropped 128 bytes below the watermark that entered it, which keeps the outputs from chattering when the count moves back and forth across a watermark.

A level state machine with three states makes these decisions:
- `LVL_NORMAL` moves to `LVL_PANIC` at or above the low watermark, or straight to `LVL_EMERG` at or above the high watermark.
- `LVL_PANIC` moves to `LVL_EMERG` at or above the high watermark, and returns to `LVL_NORMAL` at or below the low watermark minus the hysteresis.
- `LVL_EMERG` falls to `LVL_PANIC` at or below the high watermark minus the hysteresis, or all the way to `LVL_NORMAL` if the count is also at or below the low release point.
- Every other case holds the current state.

Top module: `rxwm_ctrl`

## Requirements
- R1: `fill_level` rises by one after a write, falls by one after a read, and never exceeds DEPTH (2048). In each case it changes on the clock edge that samples the strobe.
- R2: A write and a read in the same cycle leave `fill_level` unchanged while the FIFO is not empty. A read while empty is ignored, so a write and a read together at empty raise the count by one.
- R3: A write without a read while `fill_level` equals DEPTH is dropped. `overrun` is high for exactly the cycle after that write.
- R4: `dma_prio` is encoded 2'b00 for normal, 2'b01 for panic and 2'b11 for emergency, and is never 2'b10. It becomes non-zero one cycle after `fill_level` first shows at least PANIC_TH (1024).
- R5: `dma_prio` becomes 2'b11 one cycle after `fill_level` shows at least EMERG_TH (1536), from any level.
- R6: The panic level is held while `fill_level` stays above PANIC_TH-HYST (896). It returns to 2'b00 one cycle after `fill_level` shows 896 or less.
- R7: The emergency level is held while `fill_level` stays above EMERG_TH-HYST (1408). It falls to 2'b01 (or to 2'b00 if the count is also at or below 896) one cycle after `fill_level` shows 1408 or less.
- R8: `pause_req` is high for exactly one cycle, the first cycle in which `dma_prio` is 2'b11. It stays low while the emergency level persists, and pulses again on every new entry.
- R9: While reset is held and right after it is released, `fill_level` is 0, `dma_prio` is 2'b00, and `pause_req` and `overrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | MAC receiver writes one byte this cycle |
| rd_en | input | 1 | DMA engine reads one byte this cycle |
| fill_level | output | $clog2(DEPTH+1) | Bytes currently held |
| dma_prio | output | 2 | Priority level requested for the DMA engine |
| pause_req | output | 1 | One-cycle request to transmit a PAUSE frame |
| overrun | output | 1 | A write was dropped because the FIFO was full |

## Verification
`fill_level` and `overrun` are registered: they reflect a strobe one clock edge after it is sampled. `dma_prio` and `pause_req` are derived from the registered count, so they follow that count by one more edge, two edges after the strobe that moved it. The bench drives the strobes on the falling edge and compares every output at the next falling edge against a model stepped once per cycle. In that model the level is computed from the count of the previous step, which reproduces this lag exactly. The bench runs a reduced configuration (64 bytes, watermarks at 32 and 48, hysteresis 8), so directed ramps and a long pseudo-random walk can reach full, empty and every watermark and release point many times.

// File: rtl/rxwm_pkg.sv
package rxwm_pkg;

    // Priority levels; the encoding is the value driven on dma_prio.
    typedef enum logic [1:0] {
        LVL_NORMAL = 2'b00,
        LVL_PANIC  = 2'b01,
        LVL_EMERG  = 2'b11
    } level_t;

endpackage

// File: rtl/rxwm_occ_counter.sv
module rxwm_occ_counter #(
    parameter int DEPTH = 2048,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    output logic [CW-1:0] fill,
    output logic          overrun
);

    localparam logic [CW-1:0] FULL = CW'(DEPTH);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic          is_full;
    logic          is_empty;
    logic          take_wr;
    logic          take_rd;
    logic [CW-1:0] fill_nxt;

    always_comb begin
        is_full  = (fill == FULL);
        is_empty = (fill == '0);
        // A write at full is accepted only if a read frees a byte in the same cycle.
        take_wr  = wr_en && (!is_full || rd_en);
        // A read at empty has nothing to take.
        take_rd  = rd_en && !is_empty;
        unique case ({take_wr, take_rd})
            2'b10:   fill_nxt = fill + ONE;
            2'b01:   fill_nxt = fill - ONE;
            default: fill_nxt = fill;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill    <= '0;
            overrun <= 1'b0;
        end else begin
            fill    <= fill_nxt;
            overrun <= wr_en && !rd_en && is_full;
        end
    end

endmodule

// File: rtl/rxwm_level_fsm.sv
module rxwm_level_fsm
    import rxwm_pkg::*;
#(
    parameter int DEPTH    = 2048,
    parameter int PANIC_TH = 1024,
    parameter int EMERG_TH = 1536,
    parameter int HYST     = 128,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] fill,
    output level_t        level,
    output logic [1:0]    prio,
    output logic          in_emerg
);

    localparam logic [CW-1:0] P_ON  = CW'(PANIC_TH);
    localparam logic [CW-1:0] E_ON  = CW'(EMERG_TH);
    localparam logic [CW-1:0] P_OFF = CW'(PANIC_TH - HYST);
    localparam logic [CW-1:0] E_OFF = CW'(EMERG_TH - HYST);

    level_t state;
    level_t state_nxt;

    // Next-state decision
    always_comb begin
        state_nxt = state;
        unique case (state)
            LVL_NORMAL: begin
                if (fill >= E_ON)
                    state_nxt = LVL_EMERG;
                else if (fill >= P_ON)
                    state_nxt = LVL_PANIC;
            end
            LVL_PANIC: begin
                if (fill >= E_ON)
                    state_nxt = LVL_EMERG;
                else if (fill <= P_OFF)
                    state_nxt = LVL_NORMAL;
            end
            LVL_EMERG: begin
                if (fill <= P_OFF)
                    state_nxt = LVL_NORMAL;
                else if (fill <= E_OFF)
                    state_nxt = LVL_PANIC;
            end
            default: state_nxt = LVL_NORMAL;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= LVL_NORMAL;
        else
            state <= state_nxt;
    end

    // Outputs
    always_comb begin
        level    = state;
        prio     = state;
        in_emerg = (state == LVL_EMERG);
    end

endmodule

// File: rtl/rxwm_pause_gen.sv
module rxwm_pause_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic in_emerg,
    output logic pause_req
);

    logic emerg_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            emerg_d <= 1'b0;
        else
            emerg_d <= in_emerg;
    end

    // High only in the first cycle of each stay in the emergency level.
    always_comb pause_req = in_emerg && !emerg_d;

endmodule

// File: rtl/rxwm_ctrl.sv
module rxwm_ctrl
    import rxwm_pkg::*;
#(
    parameter int DEPTH    = 2048,
    parameter int PANIC_TH = 1024,
    parameter int EMERG_TH = 1536,
    parameter int HYST     = 128,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    output logic [CW-1:0] fill_level,
    output logic [1:0]    dma_prio,
    output logic          pause_req,
    output logic          overrun
);

    level_t level;
    logic   in_emerg;

    rxwm_occ_counter #(.DEPTH(DEPTH)) u_occ (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .fill    (fill_level),
        .overrun (overrun)
    );

    rxwm_level_fsm #(
        .DEPTH    (DEPTH),
        .PANIC_TH (PANIC_TH),
        .EMERG_TH (EMERG_TH),
        .HYST     (HYST)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .fill     (fill_level),
        .level    (level),
        .prio     (dma_prio),
        .in_emerg (in_emerg)
    );

    rxwm_pause_gen u_pause (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_emerg  (in_emerg),
        .pause_req (pause_req)
    );

endmodule

// File: rtl/rxwm_ctrl_chk.sv
module rxwm_ctrl_chk #(
    parameter int DEPTH    = 2048,
    parameter int PANIC_TH = 1024,
    parameter int EMERG_TH = 1536,
    parameter int HYST     = 128,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic [CW-1:0] fill_level,
    input logic [1:0]    dma_prio,
    input logic          pause_req,
    input logic          overrun
);

    localparam logic [CW-1:0] FULL  = CW'(DEPTH);
    localparam logic [CW-1:0] P_ON  = CW'(PANIC_TH);
    localparam logic [CW-1:0] E_ON  = CW'(EMERG_TH);
    localparam logic [CW-1:0] P_OFF = CW'(PANIC_TH - HYST);

    a_r1_never_above_depth: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= FULL);

    a_r1_write_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && fill_level != FULL) |=> (fill_level == $past(fill_level) + 1'b1));

    a_r2_balanced_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en && fill_level != '0) |=> $stable(fill_level));

    a_r3_drop_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && fill_level == FULL) |=> (overrun && fill_level == FULL));

    a_r4_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        dma_prio != 2'b10);

    a_r4_panic_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level >= P_ON) |=> (dma_prio != 2'b00));

    a_r5_emerg_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level >= E_ON) |=> (dma_prio == 2'b11));

    a_r6_panic_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_prio == 2'b01 && fill_level > P_OFF && fill_level < E_ON) |=> (dma_prio == 2'b01));

    a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req |=> !pause_req);

    a_r8_pulse_at_emerg: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req |-> (dma_prio == 2'b11));

endmodule

bind rxwm_ctrl rxwm_ctrl_chk #(
    .DEPTH    (DEPTH),
    .PANIC_TH (PANIC_TH),
    .EMERG_TH (EMERG_TH),
    .HYST     (HYST)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .fill_level (fill_level),
    .dma_prio   (dma_prio),
    .pause_req  (pause_req),
    .overrun    (overrun)
);

// File: tb/rxwm_ctrl_bench.sv
module rxwm_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int D  = 64;
    localparam int PA = 32;
    localparam int EM = 48;
    localparam int H  = 8;
    localparam int CW = $clog2(D + 1);
    localparam int WATCHDOG = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [CW-1:0] fill_level;
    logic [1:0]    dma_prio;
    logic          pause_req;
    logic          overrun;

    int checks = 0;
    int errors = 0;
    int e_fill = 0;
    int e_lvl  = 0;
    bit done   = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxwm_ctrl #(.DEPTH(D), .PANIC_TH(PA), .EMERG_TH(EM), .HYST(H)) u_rxwm_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .fill_level (fill_level),
        .dma_prio   (dma_prio),
        .pause_req  (pause_req),
        .overrun    (overrun)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (time %0t)", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive at the falling edge, sample at the next falling edge.
    task automatic step(input bit w, input bit r);
        int o_fill, o_lvl, n_fill, n_lvl;
        bit n_ovr, n_pause;
        string ftag, ptag;
        o_fill = e_fill;
        o_lvl  = e_lvl;
        if (o_fill >= EM)          n_lvl = 3;
        else if (o_lvl == 0)       n_lvl = (o_fill >= PA) ? 1 : 0;
        else if (o_lvl == 1)       n_lvl = (o_fill <= PA - H) ? 0 : 1;
        else if (o_fill <= PA - H) n_lvl = 0;
        else if (o_fill <= EM - H) n_lvl = 1;
        else                       n_lvl = 3;
        n_fill = o_fill;
        if (w && !r && o_fill < D) n_fill = o_fill + 1;
        if (r && !w && o_fill > 0) n_fill = o_fill - 1;
        if (w && r && o_fill == 0) n_fill = 1;
        n_ovr   = w && !r && (o_fill == D);
        n_pause = (n_lvl == 3) && (o_lvl != 3);
        ftag = (w && r) ? "R2 simultaneous/empty read" : "R1 count";
        if (n_lvl == 3 && o_lvl != 3)      ptag = "R5 emergency entry";
        else if (o_lvl == 1 && n_lvl == 0) ptag = "R6 panic release";
        else if (o_lvl == 3 && n_lvl != 3) ptag = "R7 emergency release";
        else                               ptag = "R4 priority level";
        wr_en = w;
        rd_en = r;
        @(negedge clk);
        e_fill = n_fill;
        e_lvl  = n_lvl;
        check(ftag, int'(fill_level), n_fill);
        check(ptag, int'(dma_prio), n_lvl);
        check("R8 pause pulse", int'(pause_req), int'(n_pause));
        check("R3 overrun", int'(overrun), int'(n_ovr));
    endtask

    task automatic go_to(input int target);
        while (e_fill < target) step(1'b1, 1'b0);
        while (e_fill > target) step(1'b0, 1'b1);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset values while held
        check("R9 fill in reset", int'(fill_level), 0);
        check("R9 prio in reset", int'(dma_prio), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 fill after reset", int'(fill_level), 0);
        check("R9 prio after reset", int'(dma_prio), 0);
        check("R9 pause after reset", int'(pause_req), 0);
        check("R9 overrun after reset", int'(overrun), 0);

        // Fill past capacity: crosses both watermarks and drops writes (R3)
        for (int i = 0; i < D + 6; i++) step(1'b1, 1'b0);
        // Balanced traffic at full keeps the count (R2)
        for (int i = 0; i < 5; i++) step(1'b1, 1'b1);
        // Drain to empty, then read while empty (R2)
        go_to(0);
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1);
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        // Hysteresis sweeps around each watermark (R6 R7 R8)
        for (int k = 0; k < 3; k++) begin
            go_to(EM + 1);
            go_to(EM - H + 1);
            go_to(EM);
            go_to(EM - H);
            go_to(EM - H - 2);
            go_to(EM + k);
            go_to(PA + 1);
            go_to(PA - H + 1);
            go_to(PA + 3);
            go_to(PA - H);
            go_to(PA - 1);
            go_to(PA);
            go_to(PA - H - 1 - k);
        end
        // Pseudo-random walk
        for (int i = 0; i < 20000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[3], lfsr[5] | lfsr[9]);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule